// File: doc/BRIEF.md
# Group-Partitioned Shared-Majority Single-Error-Correcting Codec

This block is a purely combinational encoder and decoder for a single-error-correcting code built on a small orthogonal Latin square base. The parity-check matrix has a base of `K_BASE = SQ*SQ` data columns, and that base is repeated once for each of `NGRP` groups. Column position `j` therefore produces the same base syndrome in every group. Extra rows carry each group's index in binary so the decoder can tell which group is at fault. A final overall-parity bit over the whole codeword separates single errors from double errors.

The write side turns a data word into its check bits. The read side takes the stored data and check bits and returns corrected data together with two flags: one for any detected error and one for a double error. Each base column has one AND of its two base syndrome bits. That AND is shared by every group's copy of the column. A per-group match on the group-index syndrome picks which copy is allowed to flip. With the defaults (`K_BASE = 4`, `NGRP = 4`) the block protects 16 data bits with 7 check bits.

Top module: `sgp_codec`

## Requirements
- R1: Data bit `n` belongs to group `n / K_BASE` at base index `j = n % K_BASE`. Check bit `j / SQ` and check bit `SQ + j % SQ` are the XOR of every data bit mapped to them. For the 16-bit default, check bit 0 equals d0^d1^d4^d5^d8^d9^d12^d13.
- R2: Check bit `2*SQ + b` is the XOR of the data bits whose group index has bit `GID_W-1-b` set, so the most significant index bit comes first. For 16 bits, data 0x0010 encodes to check bits 7'b0100101.
- R3: The last check bit (index `CHK_W-1`) equals the XOR of all data bits and all other check bits, which makes the full codeword parity even.
- R4: A stored codeword with no error is returned unchanged, with both flags low.
- R5: A single flipped data bit is corrected, the error flag is high and the double-error flag is low. Flipping d4 in the 16-bit default gives syndrome rows 0..5 = 1,0,1,0,0,1.
- R6: A single flipped check bit of any kind leaves the data unchanged, with the error flag high and the double-error flag low.
- R7: Any two flipped codeword bits raise both flags, and the data is returned exactly as read, with no bit flipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_data | input | K_BASE*NGRP | Data word to encode |
| wr_check | output | CHK_W | Check bits for wr_data |
| rd_data | input | K_BASE*NGRP | Data word as read from storage |
| rd_check | input | CHK_W | Check bits as read from storage |
| fix_data | output | K_BASE*NGRP | Corrected data word |
| err_seen | output | 1 | Any syndrome bit nonzero |
| err_fatal | output | 1 | Double error detected; data left as read |

## Verification
The bench injects every single-bit error over random words. Data bits in different groups share a base syndrome, so a broken group match would flip the same position in every group, or in the wrong one. Single errors on check bits hit exactly one syndrome row at a time. A decoder that lets the shared AND fire there would corrupt a group-0 data bit. Every pair of errors is swept for several words. A corrector that is not gated by the overall parity would miscorrect these pairs, and a wrong double-error rule would misreport the flags. Directed encodings pin the exact row and bit order of the check bits.

// File: rtl/sgp_pkg.sv
package sgp_pkg;

    // Side length of the Latin square for a base of k data bits.
    function automatic int sq_side(input int k);
        int s;
        s = 1;
        while ((s + 1) * (s + 1) <= k) s++;
        return s;
    endfunction

    function automatic int gid_width(input int ngrp);
        return (ngrp < 2) ? 1 : $clog2(ngrp);
    endfunction

    // base rows + group rows + overall parity
    function automatic int chk_width(input int k, input int ngrp);
        return 2 * sq_side(k) + gid_width(ngrp) + 1;
    endfunction

endpackage

// File: rtl/sgp_encoder.sv
module sgp_encoder
    import sgp_pkg::*;
#(
    parameter int K_BASE = 4,
    parameter int NGRP   = 4
) (
    input  logic [K_BASE*NGRP-1:0]     data,
    output logic [2*sq_side(K_BASE)-1:0] base_par,
    output logic [gid_width(NGRP)-1:0] grp_par
);
    localparam int SQ    = sq_side(K_BASE);
    localparam int GID_W = gid_width(NGRP);
    localparam int DW    = K_BASE * NGRP;

    // Mask of data bits that feed base row r (0..2*SQ-1).
    function automatic logic [DW-1:0] base_mask(input int r);
        logic [DW-1:0] m;
        m = '0;
        for (int n = 0; n < DW; n++) begin
            int j;
            j = n % K_BASE;
            if (r < SQ) m[n] = ((j / SQ) == r);
            else        m[n] = ((j % SQ) == (r - SQ));
        end
        return m;
    endfunction

    // Mask of data bits whose group index has bit i set.
    function automatic logic [DW-1:0] grp_mask(input int i);
        logic [DW-1:0] m;
        m = '0;
        for (int n = 0; n < DW; n++) begin
            m[n] = (((n / K_BASE) >> i) & 1) == 1;
        end
        return m;
    endfunction

    for (genvar r = 0; r < 2 * SQ; r++) begin : g_base
        localparam logic [DW-1:0] MASK = base_mask(r);
        assign base_par[r] = ^(data & MASK);
    end

    for (genvar i = 0; i < GID_W; i++) begin : g_grp
        localparam logic [DW-1:0] MASK = grp_mask(i);
        assign grp_par[i] = ^(data & MASK);
    end

endmodule

// File: rtl/sgp_syndrome.sv
module sgp_syndrome
    import sgp_pkg::*;
#(
    parameter int K_BASE = 4,
    parameter int NGRP   = 4,
    parameter int CHK_W  = chk_width(K_BASE, NGRP)
) (
    input  logic [K_BASE*NGRP-1:0]       rd_data,
    input  logic [CHK_W-1:0]             rd_check,
    output logic [2*sq_side(K_BASE)-1:0] base_syn,
    output logic [gid_width(NGRP)-1:0]   grp_syn,
    output logic                         all_syn
);
    localparam int SQ    = sq_side(K_BASE);
    localparam int GID_W = gid_width(NGRP);

    logic [2*SQ-1:0]  base_re;
    logic [GID_W-1:0] grp_re;

    sgp_encoder #(.K_BASE(K_BASE), .NGRP(NGRP)) u_reenc (
        .data     (rd_data),
        .base_par (base_re),
        .grp_par  (grp_re)
    );

    assign base_syn = base_re ^ rd_check[2*SQ-1:0];

    // Group rows are stored most significant index bit first.
    for (genvar i = 0; i < GID_W; i++) begin : g_gsyn
        assign grp_syn[i] = grp_re[i] ^ rd_check[2*SQ + GID_W - 1 - i];
    end

    // Parity over the full codeword as read.
    assign all_syn = ^{rd_data, rd_check};

endmodule

// File: rtl/sgp_corrector.sv
module sgp_corrector
    import sgp_pkg::*;
#(
    parameter int K_BASE = 4,
    parameter int NGRP   = 4
) (
    input  logic [2*sq_side(K_BASE)-1:0] base_syn,
    input  logic [gid_width(NGRP)-1:0]   grp_syn,
    input  logic                         all_syn,
    output logic [K_BASE*NGRP-1:0]       flip
);
    localparam int SQ    = sq_side(K_BASE);
    localparam int GID_W = gid_width(NGRP);

    logic [K_BASE-1:0] shared_and;
    logic [NGRP-1:0]   grp_hit;

    // One AND per base column, shared by every group's copy.
    for (genvar j = 0; j < K_BASE; j++) begin : g_col
        assign shared_and[j] = base_syn[j / SQ] & base_syn[SQ + (j % SQ)];
    end

    // One match per group; an even-parity syndrome never corrects.
    for (genvar g = 0; g < NGRP; g++) begin : g_match
        localparam int unsigned GI = g;
        assign grp_hit[g] = all_syn && (grp_syn == GID_W'(GI));
        for (genvar j = 0; j < K_BASE; j++) begin : g_bit
            assign flip[g*K_BASE + j] = shared_and[j] & grp_hit[g];
        end
    end

    always_comb begin
        if (!$isunknown({base_syn, grp_syn, all_syn})) begin
            assert_one_group_R5: assert ($onehot0(grp_hit))
                else $error("more than one group selected");
            assert_single_flip_R5: assert ($countones(flip) <= 1)
                else $error("more than one data bit flipped");
            assert_no_flip_even_R7: assert (all_syn || (flip == '0))
                else $error("flip with even codeword parity");
        end
    end

endmodule

// File: rtl/sgp_codec.sv
module sgp_codec
    import sgp_pkg::*;
#(
    parameter int K_BASE = 4,
    parameter int NGRP   = 4,
    parameter int CHK_W  = chk_width(K_BASE, NGRP)
) (
    input  logic [K_BASE*NGRP-1:0] wr_data,
    output logic [CHK_W-1:0]       wr_check,
    input  logic [K_BASE*NGRP-1:0] rd_data,
    input  logic [CHK_W-1:0]       rd_check,
    output logic [K_BASE*NGRP-1:0] fix_data,
    output logic                   err_seen,
    output logic                   err_fatal
);
    localparam int SQ    = sq_side(K_BASE);
    localparam int GID_W = gid_width(NGRP);
    localparam int DW    = K_BASE * NGRP;

    // ---------------- write path ----------------
    logic [2*SQ-1:0]  wr_base;
    logic [GID_W-1:0] wr_grp;

    sgp_encoder #(.K_BASE(K_BASE), .NGRP(NGRP)) u_enc (
        .data     (wr_data),
        .base_par (wr_base),
        .grp_par  (wr_grp)
    );

    assign wr_check[2*SQ-1:0] = wr_base;
    for (genvar i = 0; i < GID_W; i++) begin : g_wgrp
        assign wr_check[2*SQ + GID_W - 1 - i] = wr_grp[i];
    end
    assign wr_check[CHK_W-1] = ^wr_data ^ (^wr_check[CHK_W-2:0]);

    // ---------------- read path ----------------
    logic [2*SQ-1:0]  base_syn;
    logic [GID_W-1:0] grp_syn;
    logic             all_syn;
    logic [DW-1:0]    flip;

    sgp_syndrome #(.K_BASE(K_BASE), .NGRP(NGRP), .CHK_W(CHK_W)) u_syn (
        .rd_data  (rd_data),
        .rd_check (rd_check),
        .base_syn (base_syn),
        .grp_syn  (grp_syn),
        .all_syn  (all_syn)
    );

    sgp_corrector #(.K_BASE(K_BASE), .NGRP(NGRP)) u_cor (
        .base_syn (base_syn),
        .grp_syn  (grp_syn),
        .all_syn  (all_syn),
        .flip     (flip)
    );

    assign fix_data  = rd_data ^ flip;
    assign err_seen  = all_syn | (|base_syn) | (|grp_syn);
    assign err_fatal = !all_syn && ((|base_syn) || (|grp_syn));

    initial begin
        assert_cfg_R1: assert (SQ * SQ == K_BASE && NGRP >= 2 &&
                               CHK_W == chk_width(K_BASE, NGRP))
            else $error("bad configuration");
    end

    always_comb begin
        if (!$isunknown({rd_data, rd_check})) begin
            assert_fatal_implies_seen_R7: assert (!err_fatal || err_seen)
                else $error("double-error flag without error flag");
            assert_clean_passthru_R4: assert (err_seen || (fix_data == rd_data))
                else $error("data changed with zero syndrome");
        end
    end

endmodule

// File: tb/sgp_codec_tb.sv
module sgp_codec_tb;
    localparam int KB = 4;
    localparam int SQ = 2;
    localparam int NG = 4;
    localparam int GW = 2;
    localparam int DW = KB * NG;
    localparam int CW = 2 * SQ + GW + 1;
    localparam int TW = DW + CW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [DW-1:0] wr_data, rd_data, fix_data;
    logic [CW-1:0] wr_check, rd_check;
    logic          err_seen, err_fatal;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    sgp_codec #(.K_BASE(KB), .NGRP(NG)) u_dut (
        .wr_data   (wr_data),
        .wr_check  (wr_check),
        .rd_data   (rd_data),
        .rd_check  (rd_check),
        .fix_data  (fix_data),
        .err_seen  (err_seen),
        .err_fatal (err_fatal)
    );

    function automatic logic [CW-1:0] ref_check(input logic [DW-1:0] d);
        logic [CW-1:0] c;
        c = '0;
        for (int n = 0; n < DW; n++) begin
            if (d[n]) begin
                int j, g;
                j = n % KB;
                g = n / KB;
                c[j / SQ]      ^= 1'b1;
                c[SQ + j % SQ] ^= 1'b1;
                for (int b = 0; b < GW; b++)
                    if (((g >> (GW - 1 - b)) & 1) == 1) c[2*SQ + b] ^= 1'b1;
            end
        end
        c[CW-1] = (^d) ^ (^c[CW-2:0]);
        return c;
    endfunction

    task automatic chk_enc(input logic [DW-1:0] d, input string req);
        logic [CW-1:0] exp;
        @(negedge clk);
        wr_data = d;
        #1;
        exp = ref_check(d);
        n_checks++;
        if (wr_check !== exp) begin
            n_errors++;
            $display("FAIL %s encode data=%h got=%b exp=%b", req, d, wr_check, exp);
        end
    endtask

    task automatic chk_dec(input logic [TW-1:0] word, input logic [DW-1:0] exp_d,
                           input logic exp_s, input logic exp_f, input string req);
        @(negedge clk);
        rd_data  = word[DW-1:0];
        rd_check = word[TW-1:DW];
        #1;
        n_checks++;
        if (fix_data !== exp_d || err_seen !== exp_s || err_fatal !== exp_f) begin
            n_errors++;
            $display("FAIL %s decode in=%h got=%h/%b/%b exp=%h/%b/%b", req, word,
                     fix_data, err_seen, err_fatal, exp_d, exp_s, exp_f);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic [TW-1:0] cw;
        wr_data = '0; rd_data = '0; rd_check = '0;

        // Directed encodings: R1 row 0 example, R2 d4 example
        chk_enc(16'h0000, "R3");
        chk_enc(16'h0010, "R2");
        if (wr_check !== 7'b0100101) begin
            n_errors++;
            $display("FAIL R2 d4 encode got=%b exp=%b", wr_check, 7'b0100101);
        end
        n_checks++;
        chk_enc(16'h3333, "R1");
        chk_enc(16'h0001, "R1");
        chk_enc(16'h8000, "R2");

        // d4 alone flipped from the all-zero codeword: R5
        chk_dec({7'b0, 16'h0010}, 16'h0000, 1'b1, 1'b0, "R5");
        // zero codeword clean: R4
        chk_dec('0, 16'h0000, 1'b0, 1'b0, "R4");

        for (int w = 0; w < 40; w++) begin
            d = (w == 0) ? 16'hFFFF : DW'($urandom);
            chk_enc(d, "R1");
            cw = {ref_check(d), d};
            chk_dec(cw, d, 1'b0, 1'b0, "R4");
            for (int p = 0; p < TW; p++) begin
                logic [TW-1:0] bad;
                bad = cw ^ (TW'(1) << p);
                if (p < DW) chk_dec(bad, d, 1'b1, 1'b0, "R5");
                else        chk_dec(bad, d, 1'b1, 1'b0, "R6");
            end
            if (w < 3) begin
                for (int a = 0; a < TW; a++) begin
                    for (int b = a + 1; b < TW; b++) begin
                        logic [TW-1:0] bad;
                        bad = cw ^ (TW'(1) << a) ^ (TW'(1) << b);
                        chk_dec(bad, bad[DW-1:0], 1'b1, 1'b1, "R7");
                    end
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule